// File: doc/BRIEF.md
# SHA3-512 Sponge Absorb/Squeeze Controller

This block turns an external Keccak-f[1600] permutation engine into a complete SHA3-512 hash unit. Message bytes arrive as 128-bit words over a valid/ready port. The block packs them into 72-byte rate blocks, applies the SHA-3 padding to the final block, reorders the bytes into lane order and XORs each block into the low 576 bits of a 1600-bit state. It then starts the permutation through a start/done handshake.

The permutation engine sits outside the block. A one-cycle start pulse hands it the current state, and a done strobe returns the permuted state. A 2:1 select loads the state register with the freshly absorbed value (select low) or with the returned permutation result (select high). After the final block, the low 512 bits of the state are put back into message byte order and kept in a separate digest register. Words arriving while a permutation runs are held back. The 512-bit output is smaller than the rate, so no squeeze iteration follows.

Top module: `sha3s_sponge_ctrl`

## Requirements
- R1: Reset state: in_ready_o is 1, digest_valid_o is 0, perm_start_o is 0 and digest_o is all zeros.
- R2: The first message byte of a word sits in bits [127:120], the next in [119:112], and so on. A word without in_last_i carries 16 bytes. The word with in_last_i carries in_bytes_i bytes (0 to 16) taken from the top of the word, and its remaining lower bytes have no effect on the digest.
- R3: Bytes are grouped into 72-byte blocks, and words may straddle block boundaries. Message byte k of a block is XORed into state bits [8k+7:8k]. Absorption leaves state bits [1599:576] unchanged.
- R4: Padding XORs 0x06 into the byte after the last message byte and 0x80 into byte 71 of that block, giving 0x86 when both land on byte 71. A message of L bytes uses floor(L/72)+1 permutations, so a message that fills its last block exactly gets one extra all-padding block.
- R5: perm_start_o is a one-cycle pulse, and perm_state_o shows the absorbed state while the block waits. The value on perm_state_i when perm_done_i is high replaces the state.
- R6: in_ready_o stays low from the moment a block is absorbed until the permutation result has been taken.
- R7: digest_o bytes, from the most significant byte down, are state bytes 0 to 63 (state byte i at bits [8i+7:8i]) after the final permutation.
- R8: digest_valid_o is a one-cycle pulse. digest_o keeps its value until the next digest is produced.
- R9: After each digest the state is cleared to zero, so every message starts from an all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Message word valid |
| in_ready_o | output | 1 | Block can accept a word |
| in_data_i | input | 128 | Message word, first byte in the top bits |
| in_last_i | input | 1 | Word is the final one of the message |
| in_bytes_i | input | 5 | Byte count of the final word (0 to 16) |
| perm_start_o | output | 1 | One-cycle start pulse to the permutation engine |
| perm_state_o | output | 1600 | State handed to the permutation engine |
| perm_done_i | input | 1 | Permutation result is valid |
| perm_state_i | input | 1600 | Permuted state returned by the engine |
| digest_valid_o | output | 1 | One-cycle digest strobe |
| digest_o | output | 512 | Held SHA3-512 digest |

## Verification
The bench builds the block with its default geometry: 16-byte words, a 72-byte rate and a 64-byte digest. Because 72 is not a multiple of 16, words straddle block boundaries, and the chosen message lengths place the final byte at every kind of position: empty message, mid-word, word end, byte 71, exactly at a block end, and one past it. A stand-in permutation with three cycles of latency exposes the stall window and the handshake timing. Filler bytes and idle gaps on the input port vary between runs that are otherwise the same.

// File: rtl/sha3s_pkg.sv
package sha3s_pkg;
    localparam int LANE_W       = 64;
    localparam int LANES        = 25;
    localparam int STATE_W      = LANE_W * LANES;
    localparam int RATE_BYTES   = 72;
    localparam int WORD_BYTES   = 16;
    localparam int DIGEST_BYTES = 64;
    localparam int RATE_W       = RATE_BYTES * 8;
    localparam int WORD_W       = WORD_BYTES * 8;
    localparam int DIGEST_W     = DIGEST_BYTES * 8;
    localparam int POS_W        = $clog2(RATE_BYTES + 1);
    localparam int CNT_W        = $clog2(WORD_BYTES + 1);

    typedef enum logic [1:0] {
        S_FILL   = 2'd0,
        S_ABSORB = 2'd1,
        S_WAIT   = 2'd2
    } phase_e;

    // message-order block (byte 0 at the top) to lane order (byte 0 at the bottom)
    function automatic logic [RATE_W-1:0] flip_rate(input logic [RATE_W-1:0] v);
        logic [RATE_W-1:0] r;
        for (int j = 0; j < RATE_BYTES; j++)
            r[8*j +: 8] = v[RATE_W-8-8*j +: 8];
        return r;
    endfunction

    // lane-order state bytes back to message order for the digest
    function automatic logic [DIGEST_W-1:0] flip_digest(input logic [DIGEST_W-1:0] v);
        logic [DIGEST_W-1:0] r;
        for (int j = 0; j < DIGEST_BYTES; j++)
            r[DIGEST_W-8-8*j +: 8] = v[8*j +: 8];
        return r;
    endfunction

    // domain bits plus first pad bit after the message, closing bit in the final byte
    function automatic logic [RATE_W-1:0] pad_block(input logic [RATE_W-1:0] v,
                                                    input logic [POS_W-1:0] p);
        logic [RATE_W-1:0] r;
        r = v;
        r[RATE_W-8-8*int'(p) +: 8] = r[RATE_W-8-8*int'(p) +: 8] ^ 8'h06;
        r[7:0] = r[7:0] ^ 8'h80;
        return r;
    endfunction
endpackage

// File: rtl/sha3s_word_merge.sv
module sha3s_word_merge #(
    parameter int RATE_BYTES = 72,
    parameter int WORD_BYTES = 16,
    localparam int RATE_W = RATE_BYTES * 8,
    localparam int WORD_W = WORD_BYTES * 8,
    localparam int POS_W  = $clog2(RATE_BYTES + 1),
    localparam int CNT_W  = $clog2(WORD_BYTES + 1)
) (
    input  logic [RATE_W-1:0] blk_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  nbytes_i,
    output logic [RATE_W-1:0] blk_o,
    output logic [WORD_W-1:0] carry_o,
    output logic [CNT_W-1:0]  carry_n_o,
    output logic [POS_W:0]    newpos_o,
    output logic              full_o
);
    int end_pos;

    always_comb begin
        end_pos   = int'(pos_i) + int'(nbytes_i);
        blk_o     = blk_i;
        carry_o   = '0;
        carry_n_o = '0;
        for (int j = 0; j < RATE_BYTES; j++) begin
            int k;
            k = j - int'(pos_i);
            if (k >= 0 && k < int'(nbytes_i))
                blk_o[RATE_W-8-8*j +: 8] = word_i[WORD_W-8-8*k +: 8];
        end
        for (int c = 0; c < WORD_BYTES; c++) begin
            int k;
            k = RATE_BYTES - int'(pos_i) + c;
            if (k >= 0 && k < int'(nbytes_i))
                carry_o[WORD_W-8-8*c +: 8] = word_i[WORD_W-8-8*k +: 8];
        end
        if (end_pos > RATE_BYTES)
            carry_n_o = CNT_W'(end_pos - RATE_BYTES);
        newpos_o = (POS_W+1)'(end_pos);
        full_o   = (end_pos >= RATE_BYTES);
    end
endmodule

// File: rtl/sha3s_digest_hold.sv
module sha3s_digest_hold #(
    parameter int DW = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] value_i,
    output logic [DW-1:0] digest_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [DW-1:0] dig;
        logic          vld;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d     = h_q;
        h_d.vld = load_i;
        if (load_i)
            h_d.dig = value_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign digest_o = h_q.dig;
    assign valid_o  = h_q.vld;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r8_digest_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(digest_o));
endmodule

// File: rtl/sha3s_sponge_ctrl.sv
module sha3s_sponge_ctrl
    import sha3s_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    output logic                in_ready_o,
    input  logic [127:0]        in_data_i,
    input  logic                in_last_i,
    input  logic [4:0]          in_bytes_i,
    output logic                perm_start_o,
    output logic [1599:0]       perm_state_o,
    input  logic                perm_done_i,
    input  logic [1599:0]       perm_state_i,
    output logic                digest_valid_o,
    output logic [511:0]        digest_o
);
    typedef struct packed {
        phase_e              phase;
        logic [STATE_W-1:0]  state;
        logic [RATE_W-1:0]   blk;
        logic [POS_W-1:0]    pos;
        logic [WORD_W-1:0]   carry;
        logic [CNT_W-1:0]    carry_n;
        logic                seen_last;
        logic                padded;
        logic                start;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [CNT_W-1:0]    eff_n;
    logic [RATE_W-1:0]   m_blk;
    logic [WORD_W-1:0]   m_carry;
    logic [CNT_W-1:0]    m_carry_n;
    logic [POS_W:0]      m_newpos;
    logic                m_full;
    logic                fb_sel;
    logic [STATE_W-1:0]  absorb_val;
    logic [STATE_W-1:0]  state_in;
    logic [RATE_W-1:0]   refill_blk;
    logic                dig_load;
    logic [DIGEST_W-1:0] dig_val;

    always_comb begin
        if (!in_last_i)                         eff_n = CNT_W'(WORD_BYTES);
        else if (in_bytes_i > CNT_W'(WORD_BYTES)) eff_n = CNT_W'(WORD_BYTES);
        else                                    eff_n = in_bytes_i;
    end

    sha3s_word_merge #(
        .RATE_BYTES (RATE_BYTES),
        .WORD_BYTES (WORD_BYTES)
    ) u_merge (
        .blk_i     (r_q.blk),
        .pos_i     (r_q.pos),
        .word_i    (in_data_i),
        .nbytes_i  (eff_n),
        .blk_o     (m_blk),
        .carry_o   (m_carry),
        .carry_n_o (m_carry_n),
        .newpos_o  (m_newpos),
        .full_o    (m_full)
    );

    // 2:1 state source: absorbed input (low) or returned permutation (high)
    assign absorb_val = r_q.state ^ {{(STATE_W-RATE_W){1'b0}}, flip_rate(r_q.blk)};
    assign fb_sel     = (r_q.phase == S_WAIT);
    assign state_in   = fb_sel ? perm_state_i : absorb_val;
    assign refill_blk = {r_q.carry, {(RATE_W-WORD_W){1'b0}}};
    assign dig_val    = flip_digest(perm_state_i[DIGEST_W-1:0]);

    always_comb begin
        r_d      = r_q;
        r_d.start = 1'b0;
        dig_load = 1'b0;
        unique case (r_q.phase)
            S_FILL: begin
                if (in_valid_i) begin
                    r_d.blk     = m_blk;
                    r_d.carry   = m_carry;
                    r_d.carry_n = m_carry_n;
                    if (m_full) begin
                        r_d.seen_last = in_last_i;
                        r_d.phase     = S_ABSORB;
                    end else if (in_last_i) begin
                        r_d.blk       = pad_block(m_blk, m_newpos[POS_W-1:0]);
                        r_d.seen_last = 1'b1;
                        r_d.padded    = 1'b1;
                        r_d.phase     = S_ABSORB;
                    end else begin
                        r_d.pos = m_newpos[POS_W-1:0];
                    end
                end
            end
            S_ABSORB: begin
                r_d.state = state_in;
                r_d.blk   = '0;
                r_d.start = 1'b1;
                r_d.phase = S_WAIT;
            end
            S_WAIT: begin
                if (perm_done_i) begin
                    if (r_q.padded) begin
                        dig_load      = 1'b1;
                        r_d.state     = '0;
                        r_d.padded    = 1'b0;
                        r_d.seen_last = 1'b0;
                        r_d.pos       = '0;
                        r_d.carry     = '0;
                        r_d.carry_n   = '0;
                        r_d.phase     = S_FILL;
                    end else begin
                        r_d.state   = state_in;
                        r_d.blk     = refill_blk;
                        r_d.pos     = POS_W'(r_q.carry_n);
                        r_d.carry   = '0;
                        r_d.carry_n = '0;
                        if (r_q.seen_last) begin
                            r_d.blk    = pad_block(refill_blk, POS_W'(r_q.carry_n));
                            r_d.padded = 1'b1;
                            r_d.phase  = S_ABSORB;
                        end else begin
                            r_d.phase = S_FILL;
                        end
                    end
                end
            end
            default: r_d.phase = S_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_ready_o   = (r_q.phase == S_FILL);
    assign perm_start_o = r_q.start;
    assign perm_state_o = r_q.state;

    sha3s_digest_hold #(.DW(DIGEST_W)) u_digest (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (dig_load),
        .value_i  (dig_val),
        .digest_o (digest_o),
        .valid_o  (digest_valid_o)
    );

    a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        perm_start_o |=> !perm_start_o);
    a_r6_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == S_WAIT) |-> !in_ready_o);
    a_r9_state_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        digest_valid_o |-> (r_q.state == '0));
    a_r3_capacity_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == S_ABSORB) |=>
            (r_q.state[STATE_W-1:RATE_W] == $past(r_q.state[STATE_W-1:RATE_W])));
    a_r3_fill_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == S_FILL) |-> (r_q.pos < POS_W'(RATE_BYTES)));
endmodule

// File: tb/sim_sha3s_sponge_ctrl.sv
`timescale 1ns/1ps
module sim_sha3s_sponge_ctrl;
    localparam int NV   = 14;
    localparam int PLAT = 3;
    localparam int VLEN [NV] = '{0, 1, 15, 16, 17, 63, 71, 72, 73, 88, 143, 144, 200, 17};
    localparam int VSEED[NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 5};
    localparam int VJUNK[NV] = '{8'h00, 8'hFF, 8'hA5, 8'hFF, 8'h3C, 8'hFF, 8'h5A,
                                 8'hFF, 8'hC3, 8'hFF, 8'h0F, 8'hFF, 8'h77, 8'h00};
    localparam int VGAP [NV] = '{0, 0, 1, 0, 2, 0, 0, 3, 0, 0, 1, 0, 0, 0};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [127:0]   in_data = '0;
    logic           in_last = 1'b0;
    logic [4:0]     in_bytes = '0;
    logic           perm_start;
    logic [1599:0]  perm_state;
    logic           perm_done = 1'b0;
    logic [1599:0]  perm_res = '0;
    logic           digest_valid;
    logic [511:0]   digest;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int pulses = 0;
    int stall_bad = 0;
    logic [511:0] seen_dig = '0;

    always #2.5 clk = ~clk;

    sha3s_sponge_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
        .in_last_i(in_last), .in_bytes_i(in_bytes),
        .perm_start_o(perm_start), .perm_state_o(perm_state),
        .perm_done_i(perm_done), .perm_state_i(perm_res),
        .digest_valid_o(digest_valid), .digest_o(digest)
    );

    function automatic logic [1599:0] fake_perm(input logic [1599:0] x);
        return {x[1598:0], x[1599]} ^ {25{64'h9E3779B97F4A7C15}};
    endfunction

    function automatic logic [7:0] msgb(input int k, input int seed);
        return 8'((k * 37 + seed * 11 + 5) & 255);
    endfunction

    function automatic logic [511:0] ref_digest(input int len, input int seed);
        logic [1599:0] s;
        logic [511:0]  d;
        int nblk;
        s = '0;
        nblk = len / 72 + 1;
        for (int b = 0; b < nblk; b++) begin
            for (int j = 0; j < 72; j++) begin
                logic [7:0] v;
                int k;
                k = b * 72 + j;
                v = (k < len) ? msgb(k, seed) : 8'h00;
                if (k == len) v = v ^ 8'h06;
                if (j == 71 && b == nblk - 1) v = v ^ 8'h80;
                s[8*j +: 8] = s[8*j +: 8] ^ v;
            end
            s = fake_perm(s);
        end
        for (int i = 0; i < 64; i++) d[511-8*i -: 8] = s[8*i +: 8];
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_msg(input int len, input int seed, input int junk, input int gap);
        int nw;
        nw = (len == 0) ? 1 : (len + 15) / 16;
        for (int w = 0; w < nw; w++) begin
            logic [127:0] d;
            int nb;
            bit lst;
            lst = (w == nw - 1);
            nb = lst ? len - 16 * w : 16;
            for (int i = 0; i < 16; i++)
                d[127-8*i -: 8] = (i < nb) ? msgb(16 * w + i, seed) : 8'(junk);
            repeat (gap) @(negedge clk);
            in_valid = 1'b1;
            in_data  = d;
            in_last  = lst;
            in_bytes = 5'(nb);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    // stand-in permutation engine; also watches the stall window (R6)
    initial begin
        forever begin
            @(negedge clk);
            if (perm_start) begin
                logic [1599:0] pin;
                pin = perm_state;
                starts++;
                for (int c = 0; c < PLAT; c++) begin
                    if (in_ready) stall_bad++;
                    @(negedge clk);
                end
                perm_res  = fake_perm(pin);
                perm_done = 1'b1;
                if (in_ready) stall_bad++;
                @(negedge clk);
                perm_done = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (digest_valid) begin
                pulses++;
                seen_dig = digest;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", 512'(in_ready), 512'(1));
        chk(digest_valid == 1'b0, "R1", "digest_valid", 512'(digest_valid), 512'(0));
        chk(perm_start == 1'b0, "R1", "perm_start", 512'(perm_start), 512'(0));
        chk(digest == '0, "R1", "digest", digest, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b1 && digest == '0, "R1", "after release", digest, '0);

        for (int v = 0; v < NV; v++) begin
            logic [511:0] exp;
            int s0, p0, to, st0;
            exp = ref_digest(VLEN[v], VSEED[v]);
            s0 = starts;
            p0 = pulses;
            st0 = stall_bad;
            send_msg(VLEN[v], VSEED[v], VJUNK[v], VGAP[v]);
            to = 0;
            while (pulses == p0 && to < 3000) begin
                @(negedge clk);
                to++;
            end
            repeat (2) @(negedge clk);
            // R2 R3 R4 R7 R9: digest from a fresh zero state, filler ignored
            chk(seen_dig == exp, "R3 R4 R7 R9 R2", $sformatf("digest v%0d", v), seen_dig, exp);
            chk(digest == exp, "R7", $sformatf("digest port v%0d", v), digest, exp);
            // R4 R5 permutation count
            chk(starts - s0 == VLEN[v] / 72 + 1, "R4 R5", $sformatf("perm count v%0d", v),
                512'(starts - s0), 512'(VLEN[v] / 72 + 1));
            // R8 pulse width
            chk(pulses == p0 + 1 && digest_valid == 1'b0, "R8", $sformatf("pulse v%0d", v),
                512'(pulses - p0), 512'(1));
            // R6 no acceptance while busy
            chk(stall_bad == st0, "R6", $sformatf("stall v%0d", v),
                512'(stall_bad - st0), 512'(0));
        end

        // R8 digest held through an idle stretch
        begin
            logic [511:0] exp_last;
            exp_last = ref_digest(VLEN[NV-1], VSEED[NV-1]);
            repeat (25) @(negedge clk);
            chk(digest == exp_last && digest_valid == 1'b0, "R8", "hold idle", digest, exp_last);
        end

        // R2 variant: same short message, differing filler, compared directly
        begin
            logic [511:0] first;
            int p0;
            p0 = pulses;
            send_msg(5, 21, 8'h11, 0);
            while (pulses == p0) @(negedge clk);
            @(negedge clk);
            first = seen_dig;
            p0 = pulses;
            send_msg(5, 21, 8'hEE, 1);
            while (pulses == p0) @(negedge clk);
            @(negedge clk);
            chk(seen_dig == first, "R2", "filler bytes", seen_dig, first);
            chk(first == ref_digest(5, 21), "R2", "short message", first, ref_digest(5, 21));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule